// File: doc/BRIEF.md
# Fetch Redirect and Slot Squash Controller

This block owns the fetch address of a short in-order pipeline (fetch, register read, ALU, write-back) and decides, every cycle, where the next instruction comes from. Branches are resolved while the branch sits in the register-read stage using only a zero test on one source operand. As a result, exactly one instruction (the delay slot) has already been fetched when a branch is taken, and the hardware squashes that instruction.

Faults and interrupts are turned into forced procedure calls. The instruction in the register-read stage does not execute. In its place, the write-back path receives a write of that instruction's address plus four into the link register (index 30), and fetch jumps to a fixed low vector. The controller also tells the downstream stages which instruction to neutralise: a squashed slot keeps both its register-file and memory write enables low, and its destination is rewritten to the discard register (index 31).

Top module: `fetch_redirect_ctrl`

## Requirements
- R1: While reset is asserted, fetch_pc_o is 0 and annul_o is 1. The first register-stage slot after reset is a bubble.
- R2: With no redirect in a cycle, fetch_pc_o in the next cycle equals its current value plus 4.
- R3: A branch in a live register-stage slot is taken when (slot_operand_i == 0) equals slot_br_if_zero_i. When taken, the next fetch_pc_o is slot_target_i; otherwise fetch advances by 4.
- R4: After any redirect (taken branch, fault or interrupt), the next slot is squashed: annul_o is 1, slot_rf_we_o and slot_mem_we_o are 0, and slot_dest_o is 31.
- R5: A live slot with slot_bad_op_i set jumps fetch to 0x4. In the same cycle it drives slot_rf_we_o=1, link_sel_o=1, slot_dest_o=30, slot_mem_we_o=0, and link_data_o equal to that slot's address plus 4. Its branch request is ignored.
- R6: A live slot with irq_i set and no fault jumps fetch to 0x8 and produces the same link write as R5.
- R7: When a fault and irq_i coincide, the fault wins. An irq_i still held is taken at a later live slot.
- R8: A squashed slot raises no fault, takes no interrupt and takes no branch; fetch advances by 4.
- R9: In a live slot with no fault or interrupt, slot_rf_we_o, slot_mem_we_o and slot_dest_o pass the requests through, and link_sel_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_is_branch_i | input | 1 | Register-stage instruction is a conditional branch |
| slot_br_if_zero_i | input | 1 | 1: branch when operand is zero; 0: branch when non-zero |
| slot_operand_i | input | OPND_W | Source operand value read in the register stage |
| slot_target_i | input | ADDR_W | Branch target address |
| slot_bad_op_i | input | 1 | Register-stage opcode is illegal |
| irq_i | input | 1 | Level interrupt request |
| slot_rf_we_req_i | input | 1 | Register-stage instruction wants to write the register file |
| slot_mem_we_req_i | input | 1 | Register-stage instruction wants to write memory |
| slot_dest_i | input | IDX_W | Decoded destination register index |
| fetch_pc_o | output | ADDR_W | Address being fetched this cycle |
| annul_o | output | 1 | Register-stage instruction is squashed |
| slot_rf_we_o | output | 1 | Register-file write enable after squash and link insertion |
| slot_mem_we_o | output | 1 | Memory write enable after squash |
| slot_dest_o | output | IDX_W | Destination after squash (31) or link insertion (30) |
| link_sel_o | output | 1 | Write-back takes link_data_o instead of the ALU result |
| link_data_o | output | ADDR_W | Return address: register-stage address plus 4 |

## Verification
The clocked properties assume every input is a known 0 or 1 on each rising edge after reset. They also assume irq_i and slot_bad_op_i are levels that can be sampled in a single cycle, so a redirect and its squash follow one edge apart. The stimulus meets this by driving all inputs on the falling edge from explicit values and clearing them at the end of each scenario. The interrupt is held high across the priority case so that its late acceptance is visible at the ports.

// File: rtl/fetch_redirect_pkg.sv
package fetch_redirect_pkg;
    // Reason the fetch stream leaves the sequential path this cycle.
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_FAULT  = 2'd1,
        CAUSE_IRQ    = 2'd2,
        CAUSE_BRANCH = 2'd3
    } redirect_cause_e;
endpackage

// File: rtl/fetch_redirect_cause.sv
module fetch_redirect_cause
    import fetch_redirect_pkg::*;
#(
    parameter int OPND_W = 32
) (
    input  logic              slot_killed,
    input  logic              bad_op,
    input  logic              irq,
    input  logic              is_branch,
    input  logic              br_if_zero,
    input  logic [OPND_W-1:0] operand,
    output redirect_cause_e   cause
);
    logic opnd_zero;

    always_comb begin
        opnd_zero = (operand == '0);
        cause     = CAUSE_NONE;
        // Priority: fault over interrupt over branch; a squashed slot raises nothing.
        if (!slot_killed) begin
            if (bad_op) begin
                cause = CAUSE_FAULT;
            end else if (irq) begin
                cause = CAUSE_IRQ;
            end else if (is_branch && (opnd_zero == br_if_zero)) begin
                cause = CAUSE_BRANCH;
            end
        end
    end
endmodule

// File: rtl/fetch_slot_squash.sv
module fetch_slot_squash
    import fetch_redirect_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 5,
    parameter int LINK_IDX = 30,
    parameter int SINK_IDX = 31,
    parameter int PC_STEP  = 4
) (
    input  logic              slot_killed,
    input  redirect_cause_e   cause,
    input  logic              rf_we_req,
    input  logic              mem_we_req,
    input  logic [IDX_W-1:0]  dest_req,
    input  logic [ADDR_W-1:0] slot_pc,
    output logic              rf_we,
    output logic              mem_we,
    output logic [IDX_W-1:0]  dest,
    output logic              link_sel,
    output logic [ADDR_W-1:0] link_data
);
    localparam logic [IDX_W-1:0]  LINK_A = IDX_W'(LINK_IDX);
    localparam logic [IDX_W-1:0]  SINK_A = IDX_W'(SINK_IDX);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(PC_STEP);

    logic forced_call;

    always_comb begin
        forced_call = (cause == CAUSE_FAULT) || (cause == CAUSE_IRQ);
        link_data   = slot_pc + STEP_A;
        link_sel    = 1'b0;
        rf_we       = rf_we_req;
        mem_we      = mem_we_req;
        dest        = dest_req;
        if (slot_killed) begin
            // Injected no-op: targets the discard register, writes nothing.
            rf_we  = 1'b0;
            mem_we = 1'b0;
            dest   = SINK_A;
        end else if (forced_call) begin
            // Replace the instruction with a write of the return address.
            rf_we    = 1'b1;
            mem_we   = 1'b0;
            dest     = LINK_A;
            link_sel = 1'b1;
        end
    end
endmodule

// File: rtl/fetch_redirect_ctrl.sv
module fetch_redirect_ctrl
    import fetch_redirect_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int OPND_W    = 32,
    parameter int IDX_W     = 5,
    parameter int PC_STEP   = 4,
    parameter int RESET_PC  = 0,
    parameter int FAULT_VEC = 4,
    parameter int IRQ_VEC   = 8,
    parameter int LINK_IDX  = 30,
    parameter int SINK_IDX  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_is_branch_i,
    input  logic              slot_br_if_zero_i,
    input  logic [OPND_W-1:0] slot_operand_i,
    input  logic [ADDR_W-1:0] slot_target_i,
    input  logic              slot_bad_op_i,
    input  logic              irq_i,
    input  logic              slot_rf_we_req_i,
    input  logic              slot_mem_we_req_i,
    input  logic [IDX_W-1:0]  slot_dest_i,
    output logic [ADDR_W-1:0] fetch_pc_o,
    output logic              annul_o,
    output logic              slot_rf_we_o,
    output logic              slot_mem_we_o,
    output logic [IDX_W-1:0]  slot_dest_o,
    output logic              link_sel_o,
    output logic [ADDR_W-1:0] link_data_o
);
    localparam logic [ADDR_W-1:0] STEP_A  = ADDR_W'(PC_STEP);
    localparam logic [ADDR_W-1:0] RESET_A = ADDR_W'(RESET_PC);
    localparam logic [ADDR_W-1:0] FAULT_A = ADDR_W'(FAULT_VEC);
    localparam logic [ADDR_W-1:0] IRQ_A   = ADDR_W'(IRQ_VEC);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;          // address in fetch
        logic [ADDR_W-1:0] slot_pc;     // address of register-stage instruction
        logic              slot_killed; // register-stage instruction squashed
    } state_t;

    state_t          state_d, state_q;
    redirect_cause_e cause;

    fetch_redirect_cause #(
        .OPND_W (OPND_W)
    ) i_cause (
        .slot_killed (state_q.slot_killed),
        .bad_op      (slot_bad_op_i),
        .irq         (irq_i),
        .is_branch   (slot_is_branch_i),
        .br_if_zero  (slot_br_if_zero_i),
        .operand     (slot_operand_i),
        .cause       (cause)
    );

    fetch_slot_squash #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .LINK_IDX (LINK_IDX),
        .SINK_IDX (SINK_IDX),
        .PC_STEP  (PC_STEP)
    ) i_squash (
        .slot_killed (state_q.slot_killed),
        .cause       (cause),
        .rf_we_req   (slot_rf_we_req_i),
        .mem_we_req  (slot_mem_we_req_i),
        .dest_req    (slot_dest_i),
        .slot_pc     (state_q.slot_pc),
        .rf_we       (slot_rf_we_o),
        .mem_we      (slot_mem_we_o),
        .dest        (slot_dest_o),
        .link_sel    (link_sel_o),
        .link_data   (link_data_o)
    );

    always_comb begin
        state_d             = state_q;
        state_d.slot_pc     = state_q.pc;
        state_d.slot_killed = (cause != CAUSE_NONE);
        case (cause)
            CAUSE_FAULT:  state_d.pc = FAULT_A;
            CAUSE_IRQ:    state_d.pc = IRQ_A;
            CAUSE_BRANCH: state_d.pc = slot_target_i;
            default:      state_d.pc = state_q.pc + STEP_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pc          <= RESET_A;
            state_q.slot_pc     <= RESET_A;
            state_q.slot_killed <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign fetch_pc_o = state_q.pc;
    assign annul_o    = state_q.slot_killed;

    // Assertions
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (fetch_pc_o == RESET_A) && annul_o);

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_sel_o && !(slot_is_branch_i && !annul_o)) |=>
        (fetch_pc_o == $past(fetch_pc_o) + STEP_A));

    assert_slot_squashed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        annul_o |-> (!slot_rf_we_o && !slot_mem_we_o && slot_dest_o == IDX_W'(SINK_IDX)));

    assert_fault_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!annul_o && slot_bad_op_i) |=> (fetch_pc_o == FAULT_A) && annul_o);

    assert_irq_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!annul_o && !slot_bad_op_i && irq_i) |=> (fetch_pc_o == IRQ_A) && annul_o);

    assert_killed_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        annul_o |=> (fetch_pc_o == $past(fetch_pc_o) + STEP_A) && !annul_o);
endmodule

// File: tb/test_fetch_redirect_ctrl.sv
module test_fetch_redirect_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int OW = 32;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          is_br = 1'b0, br_z = 1'b0, bad = 1'b0, irq = 1'b0;
    logic          we_req = 1'b0, mwe_req = 1'b0;
    logic [OW-1:0] opnd = '0;
    logic [AW-1:0] tgt = '0;
    logic [IW-1:0] rc = '0;
    logic [AW-1:0] fetch_pc, link_data;
    logic          annul, rf_we, mem_we, link_sel;
    logic [IW-1:0] dest;

    int checks = 0;
    int fails  = 0;
    logic [AW-1:0] p;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_redirect_ctrl i_fetch_redirect_ctrl (
        .clk(clk), .rst_n(rst_n),
        .slot_is_branch_i(is_br), .slot_br_if_zero_i(br_z),
        .slot_operand_i(opnd), .slot_target_i(tgt),
        .slot_bad_op_i(bad), .irq_i(irq),
        .slot_rf_we_req_i(we_req), .slot_mem_we_req_i(mwe_req), .slot_dest_i(rc),
        .fetch_pc_o(fetch_pc), .annul_o(annul),
        .slot_rf_we_o(rf_we), .slot_mem_we_o(mem_we), .slot_dest_o(dest),
        .link_sel_o(link_sel), .link_data_o(link_data)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        is_br = 0; br_z = 0; bad = 0; irq = 0;
        we_req = 0; mwe_req = 0; opnd = '0; tgt = '0; rc = '0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        tick(); tick();
        check("R1", "pc in reset", fetch_pc, 0);
        check("R1", "annul in reset", {31'd0, annul}, 1);
        rst_n = 1;
        // first slot is squashed: requests must be ignored (R8)
        bad = 1; irq = 1; is_br = 1; br_z = 1; opnd = '0; tgt = 32'h300;
        #1;
        check("R8", "no link on killed slot", {31'd0, link_sel}, 0);
        tick();
        check("R8", "killed slot steps pc", fetch_pc, 4);
        check("R8", "annul clears", {31'd0, annul}, 0);
        clear_inputs();
    endtask

    task automatic t_sequential();
        p = fetch_pc;
        we_req = 1; mwe_req = 1; rc = 5'd7;
        #1;
        check("R9", "rf_we pass", {31'd0, rf_we}, 1);
        check("R9", "mem_we pass", {31'd0, mem_we}, 1);
        check("R9", "dest pass", {27'd0, dest}, 7);
        check("R9", "no link", {31'd0, link_sel}, 0);
        tick();
        check("R2", "step 1", fetch_pc, p + 4);
        tick();
        check("R2", "step 2", fetch_pc, p + 8);
        clear_inputs();
    endtask

    task automatic t_branch();
        // taken on zero
        is_br = 1; br_z = 1; opnd = '0; tgt = 32'h100;
        tick();
        check("R3", "taken on zero", fetch_pc, 32'h100);
        clear_inputs();
        we_req = 1; mwe_req = 1; rc = 5'd9;
        #1;
        check("R4", "slot annulled", {31'd0, annul}, 1);
        check("R4", "slot rf_we low", {31'd0, rf_we}, 0);
        check("R4", "slot mem_we low", {31'd0, mem_we}, 0);
        check("R4", "slot dest sink", {27'd0, dest}, 31);
        tick();
        clear_inputs();
        check("R2", "after slot", fetch_pc, 32'h104);
        // not taken: zero-test fails
        p = fetch_pc;
        is_br = 1; br_z = 1; opnd = 32'd5; tgt = 32'h200;
        tick();
        check("R3", "not taken on nonzero", fetch_pc, p + 4);
        check("R3", "no annul when not taken", {31'd0, annul}, 0);
        // taken on nonzero
        is_br = 1; br_z = 0; opnd = 32'd5; tgt = 32'h200;
        tick();
        check("R3", "taken on nonzero", fetch_pc, 32'h200);
        check("R4", "annul after nonzero branch", {31'd0, annul}, 1);
        clear_inputs();
        tick();
        tick();
    endtask

    task automatic t_fault();
        p = fetch_pc;                 // register-stage address is p-4
        bad = 1; is_br = 1; br_z = 1; opnd = '0; tgt = 32'h400;
        we_req = 0; mwe_req = 1; rc = 5'd3;
        #1;
        check("R5", "link select", {31'd0, link_sel}, 1);
        check("R5", "link dest 30", {27'd0, dest}, 30);
        check("R5", "link write", {31'd0, rf_we}, 1);
        check("R5", "no mem write", {31'd0, mem_we}, 0);
        check("R5", "link data", link_data, p);
        tick();
        check("R5", "fault vector", fetch_pc, 4);
        check("R4", "annul after fault", {31'd0, annul}, 1);
        clear_inputs();
        tick();
        tick();
    endtask

    task automatic t_irq();
        p = fetch_pc;
        irq = 1; mwe_req = 1;
        #1;
        check("R6", "link select", {31'd0, link_sel}, 1);
        check("R6", "link data", link_data, p);
        check("R6", "no mem write", {31'd0, mem_we}, 0);
        tick();
        check("R6", "irq vector", fetch_pc, 8);
        irq = 0;
        check("R4", "annul after irq", {31'd0, annul}, 1);
        tick();
        tick();
    endtask

    task automatic t_priority();
        bad = 1; irq = 1;
        tick();
        check("R7", "fault wins", fetch_pc, 4);
        bad = 0;                      // irq held; slot now killed
        tick();
        check("R7", "killed slot ignores irq", fetch_pc, 8);
        #1;
        check("R7", "late irq link", {31'd0, link_sel}, 1);
        check("R7", "late irq link data", link_data, 8);
        tick();
        check("R7", "late irq vector", fetch_pc, 8);
        clear_inputs();
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sequential();
        t_branch();
        t_fault();
        t_irq();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule